// File: doc/BRIEF.md
# Segment-Controlled Address Translator

This block turns a 32-bit virtual address into either a physical address or a request for a page-table lookup. The address space is cut into six segments. Each segment reads its own 16-bit control half-word from one of three 32-bit segment-control inputs. That half-word holds a 3-bit access-mode code, an error-unmapped flag and a 7-bit physical base. The requester's privilege level is decoded against the access-mode code and gives one of three outcomes: address error, mapped (the address goes to the lookup unit), or unmapped (a physical address is formed directly).

A request carries an address and a privilege level, and is marked by a valid strobe. The answer appears on the response port one clock later. The response holds a status code, a 36-bit physical address, read/write/execute permissions, a lookup-needed flag and the virtual address to hand to the lookup unit. The lookup unit itself, exception handling and cache attributes lie outside this block.

Top module: `seg_xlate`

## Requirements
- R1: A request with `req_valid` high produces `rsp_valid` high on the next clock edge. With `req_valid` low, `rsp_valid` goes low on the next edge and every other response output keeps its previous value.
- R2: Segment selection: addresses 0x0000_0000..0x3FFF_FFFF use `seg_ctl2[31:16]` and 0x4000_0000..0x7FFF_FFFF use `seg_ctl2[15:0]`, both with offset mask 0x3FFF_FFFF. Addresses from 0x8000_0000, 0xA000_0000, 0xC000_0000 and 0xE000_0000 (each 512 MB) use `seg_ctl1[31:16]`, `seg_ctl1[15:0]`, `seg_ctl0[31:16]` and `seg_ctl0[15:0]` in that order, with offset mask 0x1FFF_FFFF.
- R3: Within a control half-word, bits 15:9 are the physical base, bits 6:4 the access-mode code and bit 3 the error-unmapped flag. Bits 8:7 and 2:0 have no effect.
- R4: Kernel level (`req_mode`=0) is mapped for codes 1, 2 and 3, unmapped for codes 0, 4, 5 and 7, and never gets an address error from codes other than 6.
- R5: Supervisor level (`req_mode`=1) gets an address error for codes 0 and 1, is mapped for codes 2, 3 and 4, and is unmapped for codes 5 and 7.
- R6: User level (`req_mode`=2) gets an address error for codes 0, 1, 2 and 5, is mapped for codes 3 and 4, and is unmapped for code 7.
- R7: Error level (`req_mode`=3) follows the kernel rules. When the segment's error-unmapped flag is 1 it is unmapped for every code except 6.
- R8: Access-mode code 6 gives an address error at every privilege level, whatever the error-unmapped flag.
- R9: An unmapped result gives `rsp_paddr` = (base << 29 with the offset-mask bits cleared) OR (address AND offset mask), as a 36-bit value.
- R10: An unmapped result gives `rsp_perm` = 3'b111 (bit 0 read, bit 1 write, bit 2 execute). Any other result gives `rsp_perm` = 0 and `rsp_paddr` = 0.
- R11: A mapped result raises `rsp_tlb_req` and puts the request address on `rsp_tlb_vaddr`. Otherwise `rsp_tlb_req` is 0 and `rsp_tlb_vaddr` is 0.
- R12: `rsp_status` is 0 for unmapped, 1 for mapped and 2 for address error. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_mode | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 user, 3 error level |
| seg_ctl0 | input | 32 | Control for the two top 512 MB segments |
| seg_ctl1 | input | 32 | Control for the two middle 512 MB segments |
| seg_ctl2 | input | 32 | Control for the two 1 GB low segments |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 unmapped, 1 mapped, 2 address error |
| rsp_paddr | output | 36 | Physical address for an unmapped result |
| rsp_perm | output | 3 | Execute, write, read permission bits |
| rsp_tlb_req | output | 1 | Lookup needed |
| rsp_tlb_vaddr | output | 32 | Address passed to the lookup unit |

## Verification
The assertions assume that the control inputs and `req_mode` are stable and known whenever reset is inactive. They also assume that each request's address and level are held through the clock edge that captures them. The bench sets all inputs to zero before reset is released. It changes the control words and the request fields only on falling edges, so every sample taken at a rising edge sees settled values. The sweep covers every segment, access-mode code, flag value and privilege level. Offsets are placed at the segment bottom, at the segment top and at a mixed pattern, and the unused control bits are filled with nonzero values.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int VA_W      = 32;
  localparam int HW_W      = 16;
  localparam int CTL_W     = 2 * HW_W;
  localparam int NUM_CTL   = 3;
  localparam int NUM_SEG   = 2 * NUM_CTL;
  localparam int PA_FLD_HI = 15;
  localparam int PA_FLD_LO = 9;
  localparam int PA_FLD_W  = PA_FLD_HI - PA_FLD_LO + 1;
  localparam int AM_HI     = 6;
  localparam int AM_LO     = 4;
  localparam int AM_W      = AM_HI - AM_LO + 1;
  localparam int EU_BIT    = 3;
  localparam int PA_SHIFT  = 20;
  localparam int BASE_POS  = PA_FLD_LO + PA_SHIFT;
  localparam int PA_W      = BASE_POS + PA_FLD_W;
  localparam int PERM_W    = 3;
  localparam int LOW_SEGS  = 2;
  localparam int LOW_LOG   = 30;
  localparam int HIGH_LOG  = 29;
  localparam logic [VA_W:0] HIGH_BASE = 33'h0_8000_0000;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_USER = 2'd2,
    MODE_ERRL = 2'd3
  } xmode_e;

  typedef enum logic [1:0] {
    ST_MATCH = 2'd0,
    ST_TLB   = 2'd1,
    ST_BAD   = 2'd2,
    ST_RSVD  = 2'd3
  } xstat_e;

  typedef struct packed {
    logic [PA_FLD_W-1:0] pa;
    logic [AM_W-1:0]     am;
    logic                eu;
  } segctl_t;

  localparam logic [AM_W-1:0] AM_RESERVED = 3'd6;

  // Decode an access-mode code against a privilege level.
  function automatic xstat_e decode_am(logic [AM_W-1:0] am, logic eu, xmode_e m);
    xstat_e r;
    logic   kern_rules;
    r          = ST_MATCH;
    kern_rules = 1'b0;
    if (am == AM_RESERVED) begin
      r = ST_BAD;
    end else begin
      unique case (m)
        MODE_ERRL: begin
          if (eu) r = ST_MATCH;
          else    kern_rules = 1'b1;
        end
        MODE_KERN: kern_rules = 1'b1;
        MODE_SUPV: begin
          if (am inside {3'd0, 3'd1})             r = ST_BAD;
          else if (am inside {3'd2, 3'd3, 3'd4})  r = ST_TLB;
          else                                    r = ST_MATCH;
        end
        MODE_USER: begin
          if (am inside {3'd0, 3'd1, 3'd2, 3'd5}) r = ST_BAD;
          else if (am inside {3'd3, 3'd4})        r = ST_TLB;
          else                                    r = ST_MATCH;
        end
        default: r = ST_BAD;
      endcase
      if (kern_rules) begin
        r = (am inside {3'd1, 3'd2, 3'd3}) ? ST_TLB : ST_MATCH;
      end
    end
    return r;
  endfunction

  // Physical address of an unmapped access.
  function automatic logic [PA_W-1:0] unmapped_pa(logic [PA_FLD_W-1:0] pa,
                                                  logic [VA_W-1:0] va,
                                                  logic [VA_W-1:0] mask);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] m_ext;
    base  = PA_W'(pa) << BASE_POS;
    m_ext = PA_W'(mask);
    return (base & ~m_ext) | (PA_W'(va) & m_ext);
  endfunction

endpackage

// File: rtl/seg_sel.sv
module seg_sel
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  va,
  input  logic [CTL_W-1:0] ctl0,
  input  logic [CTL_W-1:0] ctl1,
  input  logic [CTL_W-1:0] ctl2,
  output logic [HW_W-1:0]  hw,
  output logic [VA_W-1:0]  mask
);

  logic [CTL_W-1:0] ctl_all [NUM_CTL];
  logic [HW_W-1:0]  hw_arr  [NUM_SEG];
  logic [VA_W-1:0]  mask_arr[NUM_SEG];
  logic [NUM_SEG-1:0] seg_hit;

  assign ctl_all[0] = ctl0;
  assign ctl_all[1] = ctl1;
  assign ctl_all[2] = ctl2;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    localparam int SZ_LOG = (k < LOW_SEGS) ? LOW_LOG : HIGH_LOG;
    localparam logic [VA_W:0] BASE = (k < LOW_SEGS) ?
      ((VA_W+1)'(k) << LOW_LOG) :
      (HIGH_BASE + ((VA_W+1)'(k - LOW_SEGS) << HIGH_LOG));
    localparam logic [VA_W:0] TOP = BASE + ((VA_W+1)'(1) << SZ_LOG);
    localparam int REG = NUM_CTL - 1 - k / 2;

    assign seg_hit[k]  = ({1'b0, va} >= BASE) && ({1'b0, va} < TOP);
    assign mask_arr[k] = VA_W'(((VA_W+1)'(1) << SZ_LOG) - 1);
    if (k % 2 == 0) begin : g_up
      assign hw_arr[k] = ctl_all[REG][CTL_W-1:HW_W];
    end else begin : g_lo
      assign hw_arr[k] = ctl_all[REG][HW_W-1:0];
    end
  end

  always_comb begin
    hw   = '0;
    mask = '0;
    for (int k = 0; k < NUM_SEG; k++) begin
      if (seg_hit[k]) begin
        hw   = hw_arr[k];
        mask = mask_arr[k];
      end
    end
  end

  // R2: every address falls in exactly one segment
  p_one_segment_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(seg_hit));

  // R2: the low half of the space uses the wide offset mask
  p_low_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !va[VA_W-1] |-> mask == 32'h3FFF_FFFF);

endmodule

// File: rtl/seg_am_dec.sv
module seg_am_dec
  import seg_xlate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HW_W-1:0] hw,
  input  logic [1:0]      mode,
  output segctl_t         fld,
  output xstat_e          status
);

  logic unused_hw_bits;
  assign unused_hw_bits = ^{hw[PA_FLD_LO-1:AM_HI+1], hw[EU_BIT-1:0]};

  assign fld.pa = hw[PA_FLD_HI:PA_FLD_LO];
  assign fld.am = hw[AM_HI:AM_LO];
  assign fld.eu = hw[EU_BIT];

  assign status = decode_am(fld.am, fld.eu, xmode_e'(mode));

  // R4: kernel level never faults on a defined code
  p_kernel_no_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && hw[AM_HI:AM_LO] != 3'd6) |-> status != ST_BAD);

  // R7: error level with the unmapped flag set bypasses mapping
  p_errl_eu_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && hw[EU_BIT] && hw[AM_HI:AM_LO] != 3'd6) |-> status == ST_MATCH);

  // R8: the reserved code faults everywhere
  p_reserved_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw[AM_HI:AM_LO] == 3'd6 |-> status == ST_BAD);

  // R6: user level is never mapped through codes outside 3 and 4
  p_user_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && status == ST_TLB) |-> hw[AM_HI:AM_LO] inside {3'd3, 3'd4});

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_mode,
  input  logic [31:0] seg_ctl0,
  input  logic [31:0] seg_ctl1,
  input  logic [31:0] seg_ctl2,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic [35:0] rsp_paddr,
  output logic [2:0]  rsp_perm,
  output logic        rsp_tlb_req,
  output logic [31:0] rsp_tlb_vaddr
);

  localparam logic [PERM_W-1:0] PERM_ALL = '1;

  logic [HW_W-1:0] sel_hw;
  logic [VA_W-1:0] sel_mask;
  segctl_t         sel_fld;
  xstat_e          dec_status;
  logic [PA_W-1:0] flat_pa;
  logic            is_match;
  logic            is_tlb;

  seg_sel u_sel (
    .clk  (clk),
    .rst_n(rst_n),
    .va   (req_addr),
    .ctl0 (seg_ctl0),
    .ctl1 (seg_ctl1),
    .ctl2 (seg_ctl2),
    .hw   (sel_hw),
    .mask (sel_mask)
  );

  seg_am_dec u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .hw    (sel_hw),
    .mode  (req_mode),
    .fld   (sel_fld),
    .status(dec_status)
  );

  assign flat_pa  = unmapped_pa(sel_fld.pa, req_addr, sel_mask);
  assign is_match = (dec_status == ST_MATCH);
  assign is_tlb   = (dec_status == ST_TLB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_status    <= ST_MATCH;
      rsp_paddr     <= '0;
      rsp_perm      <= '0;
      rsp_tlb_req   <= 1'b0;
      rsp_tlb_vaddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status    <= dec_status;
        rsp_paddr     <= is_match ? flat_pa : '0;
        rsp_perm      <= is_match ? PERM_ALL : '0;
        rsp_tlb_req   <= is_tlb;
        rsp_tlb_vaddr <= is_tlb ? req_addr : '0;
      end
    end
  end

  // R1: one response per request, one cycle later
  p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)));

  // R10: permissions only on an unmapped result
  p_perm_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_MATCH) |-> rsp_perm == PERM_ALL);
  p_perm_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status != ST_MATCH |-> (rsp_perm == '0 && rsp_paddr == '0));

  // R11: the lookup address is the request address
  p_tlb_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_tlb_req == (rsp_status == ST_TLB)) &&
                  (!rsp_tlb_req || rsp_tlb_vaddr == $past(req_addr)));

  // R12: the reserved status code is never produced
  p_status_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status != ST_RSVD);

endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_mode = '0;
  logic [31:0] seg_ctl0 = '0;
  logic [31:0] seg_ctl1 = '0;
  logic [31:0] seg_ctl2 = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [35:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        rsp_tlb_req;
  logic [31:0] rsp_tlb_vaddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_mode(req_mode), .seg_ctl0(seg_ctl0), .seg_ctl1(seg_ctl1),
    .seg_ctl2(seg_ctl2), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_tlb_req(rsp_tlb_req),
    .rsp_tlb_vaddr(rsp_tlb_vaddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Expected status from per-level code sets (bit n set = code n)
  function automatic logic [1:0] exp_status(int am, int eu, int mode);
    logic [7:0] bad_set, map_set;
    if (am == 6) return 2'd2;
    if (mode == 3 && eu == 1) return 2'd0;
    case (mode)
      1:       begin bad_set = 8'b0000_0011; map_set = 8'b0001_1100; end
      2:       begin bad_set = 8'b0010_0111; map_set = 8'b0001_1000; end
      default: begin bad_set = 8'b0000_0000; map_set = 8'b0000_1110; end
    endcase
    if (bad_set[am]) return 2'd2;
    if (map_set[am]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic string status_tag(int am, int mode);
    if (am == 6) return "R8";
    case (mode)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, mask, addr, off, fill;
    logic [15:0] hw;
    logic [6:0]  pa;
    logic [1:0]  es;
    logic [35:0] epa;
    logic [35:0] last_pa;
    logic [1:0]  last_st;

    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R10 reset rsp_perm", 64'(rsp_perm), 64'd0);
    chk("R11 reset rsp_tlb_req", 64'(rsp_tlb_req), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int seg = 0; seg < 6; seg++) begin
      case (seg)
        0: base = 32'h0000_0000;
        1: base = 32'h4000_0000;
        2: base = 32'h8000_0000;
        3: base = 32'hA000_0000;
        4: base = 32'hC000_0000;
        default: base = 32'hE000_0000;
      endcase
      mask = (seg < 2) ? 32'h3FFF_FFFF : 32'h1FFF_FFFF;
      for (int am = 0; am < 8; am++) begin
        for (int eu = 0; eu < 2; eu++) begin
          for (int mode = 0; mode < 4; mode++) begin
            pa = 7'(seg * 19 + am * 5 + eu * 3 + mode * 11 + 1);
            // R3: unused bits 8:7 and 2:0 carry nonzero filler
            hw = {pa, 2'b11, 3'(am), 1'(eu), 3'b101};
            fill = {~pa, 2'b00, 3'(am) ^ 3'b101, ~1'(eu), 3'b010,
                    ~pa, 2'b01, 3'(am) ^ 3'b011, ~1'(eu), 3'b001};
            case (mode)
              0: off = 32'h0;
              1: off = 32'hFFFF_FFFF;
              default: off = 32'h1357_9BDF * 32'(seg * 64 + am * 8 + eu * 4 + mode + 1);
            endcase
            addr = base | (off & mask);
            @(negedge clk);
            seg_ctl0 = fill; seg_ctl1 = fill; seg_ctl2 = fill;
            case (seg)
              0: seg_ctl2[31:16] = hw;
              1: seg_ctl2[15:0]  = hw;
              2: seg_ctl1[31:16] = hw;
              3: seg_ctl1[15:0]  = hw;
              4: seg_ctl0[31:16] = hw;
              default: seg_ctl0[15:0] = hw;
            endcase
            req_valid = 1'b1;
            req_addr  = addr;
            req_mode  = 2'(mode);
            @(posedge clk);
            #1;
            es  = exp_status(am, eu, mode);
            epa = (({pa, 29'd0}) & ~{4'h0, mask}) | {4'h0, addr & mask};
            chk("R1 rsp_valid", 64'(rsp_valid), 64'd1);
            chk($sformatf("%s R12 R2 R3 status seg%0d am%0d eu%0d mode%0d",
                          status_tag(am, mode), seg, am, eu, mode),
                64'(rsp_status), 64'(es));
            chk($sformatf("R9 R2 paddr seg%0d am%0d", seg, am),
                64'(rsp_paddr), (es == 2'd0) ? 64'(epa) : 64'd0);
            chk("R10 perm", 64'(rsp_perm), (es == 2'd0) ? 64'd7 : 64'd0);
            chk("R11 tlb_req", 64'(rsp_tlb_req), (es == 2'd1) ? 64'd1 : 64'd0);
            chk("R11 tlb_vaddr", 64'(rsp_tlb_vaddr), (es == 2'd1) ? 64'(addr) : 64'd0);
          end
        end
      end
    end

    // R1: idle cycle leaves outputs unchanged apart from rsp_valid
    last_pa = rsp_paddr;
    last_st = rsp_status;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 32'h1234_5678;
    req_mode  = 2'd0;
    seg_ctl2  = 32'h0070_0070;
    @(posedge clk);
    #1;
    chk("R1 idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 idle paddr held", 64'(rsp_paddr), 64'(last_pa));
    chk("R1 idle status held", 64'(rsp_status), 64'(last_st));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule